// File: doc/BRIEF.md
# Interrupt Wake Threshold Controller

This block holds one small control register and the decision logic behind it. A power-management sequencer uses it to learn whether the highest pending interrupt request is urgent enough to bring a core out of stop or wait mode. The register also selects where a request at the top priority level (level 7) is sent: to the normal interrupt path, to a fast-interrupt path, or to a transfer-trigger input of a DMA-style engine.

Software programs a three-bit wake threshold, a fast-interrupt enable and a DMA-routing enable through a simple write strobe and a combinational read-back bus. The arbiter upstream presents the priority level of its winning request together with a valid flag. The block answers with a registered wake flag and, when a valid level-7 request first appears, a one-cycle pulse on exactly one of three routing outputs. The DMA-routing enable is sticky: once set, only reset clears it, and it can never be on at the same time as the fast-interrupt enable.

Top module: `irq_wake_ctl`

## Requirements
- R1: Reset is synchronous and active low. After reset, cfg_rdata reads 0x00 and wake, rt_normal, rt_fast and rt_dma are all 0.
- R2: One clock after a valid request is sampled, wake is 1 exactly when req_level (unsigned binary, 0 to 7) is strictly greater than the threshold held in register bits [2:0].
- R3: A request whose level equals or is below the threshold, or any request with req_valid at 0, leaves wake at 0 one clock later.
- R4: A write stores cfg_wdata[2:0] as the threshold, and cfg_rdata[2:0] returns it as plain binary (000 = level 0 through 111 = level 7).
- R5: Register bit 3 is the fast-interrupt enable; while it is 1 (and bit 5 is 0), a new level-7 request pulses rt_fast.
- R6: Register bit 5 is the DMA-routing enable; while it is 1, a new level-7 request pulses rt_dma. Once bit 5 reads 1, later writes of 0 leave it at 1 until reset.
- R7: A write that sets bit 5 has no effect on bit 5 while bit 3 currently reads 1.
- R8: A write that sets bit 3 has no effect on bit 3 while bit 5 reads 1 or is being set by the same write, so bits 3 and 5 never read 1 together.
- R9: Bits 7, 6 and 4 are not implemented: writes to them change nothing and they read as 0.
- R10: When req_valid is 1 and req_level is 7 in a cycle where the previous cycle held no such request, exactly one routing output is 1 on the following cycle, for that one cycle only; a held level-7 request gives no further pulse, and lower levels give none.
- R11: With bits 3 and 5 both 0, a new level-7 request pulses rt_normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe, one write per cycle it is high |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back, combinational |
| req_valid | input | 1 | A pending request is presented |
| req_level | input | 3 | Priority level of the pending request |
| wake | output | 1 | Registered wake decision |
| rt_normal | output | 1 | Level-7 request routed to the normal interrupt path (pulse) |
| rt_fast | output | 1 | Level-7 request routed to the fast-interrupt path (pulse) |
| rt_dma | output | 1 | Level-7 request routed as a transfer trigger (pulse) |

## Verification
The embedded properties assume that req_valid, req_level, cfg_we and cfg_wdata carry known values at every rising edge once reset is released, and that the routing mode bits a property reads are the ones held when the request is sampled. The stimulus changes every input only on the falling edge, so each rising edge sees settled, defined values, and it keeps req_valid low during register writes so that a mode change never coincides with the arrival of a level-7 request. The sweep walks every threshold against every level with the valid flag both low and high, and directed sequences then drive the mode bits through their allowed and refused transitions.

// File: rtl/irq_wake_pkg.sv
// Package irq_wake_pkg
// Shared widths, register bit positions and the routing choice type for the
// interrupt wake threshold controller. Assumes an 8-bit register with a
// three-bit priority level field.
package irq_wake_pkg;

    localparam int LVL_W    = 3;
    localparam int REG_W    = 8;
    localparam int THR_LSB  = 0;
    localparam int FAST_BIT = 3;
    localparam int DMA_BIT  = 5;
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

    // Held register content (implemented bits only).
    typedef struct packed {
        logic             dma_en;
        logic             fast_en;
        logic [LVL_W-1:0] thr;
    } wake_cfg_t;

    // Destination for a top-level request.
    typedef enum logic [1:0] {
        RT_NORMAL = 2'd0,
        RT_FAST   = 2'd1,
        RT_DMA    = 2'd2
    } route_t;

endpackage

// File: rtl/wake_cfg_reg.sv
// Module wake_cfg_reg
// Holds the wake threshold, the fast-interrupt enable and the sticky
// DMA-routing enable. Assumes one write per cycle on cfg_we. The DMA enable
// can only be set while fast is off, and fast can only be set while DMA is
// off and not being set by the same write. Unimplemented bits read 0.
module wake_cfg_reg
    import irq_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output wake_cfg_t        cfg
);

    wake_cfg_t  cfg_q;
    wake_cfg_t  cfg_d;
    logic       dma_set;
    logic       dma_next;
    logic       unused_wbits;

    // Bits of the write bus that have no storage behind them.
    assign unused_wbits = ^{cfg_wdata[7:6], cfg_wdata[4]};

    // Next register value under the exclusion and stickiness rules.
    always_comb begin
        dma_set  = cfg_wdata[DMA_BIT] && !cfg_q.fast_en;
        dma_next = cfg_q.dma_en || dma_set;
        cfg_d    = cfg_q;
        if (cfg_we) begin
            cfg_d.thr     = cfg_wdata[THR_LSB +: LVL_W];
            cfg_d.dma_en  = dma_next;
            cfg_d.fast_en = cfg_wdata[FAST_BIT] && !dma_next;
        end
    end

    // Register state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Read-back assembly, unimplemented positions forced low.
    always_comb begin
        cfg_rdata                        = '0;
        cfg_rdata[THR_LSB +: LVL_W]      = cfg_q.thr;
        cfg_rdata[FAST_BIT]              = cfg_q.fast_en;
        cfg_rdata[DMA_BIT]               = cfg_q.dma_en;
    end

    assign cfg = cfg_q;

    AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.dma_en |=> cfg_q.dma_en); // R6

    AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !(cfg_q.dma_en && cfg_q.fast_en)); // R8

    AST_DMA_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_q.fast_en && !cfg_q.dma_en) |=> !cfg_q.dma_en); // R7

    AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[THR_LSB +: LVL_W] == $past(cfg_wdata[THR_LSB +: LVL_W]))); // R4

endmodule

// File: rtl/wake_cmp.sv
// Module wake_cmp
// Registered strict greater-than comparison of the pending request level
// against the programmed threshold. Assumes req_level is only meaningful
// while req_valid is high.
module wake_cmp
    import irq_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] thr,
    output logic             wake
);

    logic above;

    // Strictly above the threshold; an equal level does not qualify.
    always_comb begin
        above = req_valid && (req_level > thr);
    end

    // Wake flag updated one clock after the request is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake <= 1'b0;
        end else begin
            wake <= above;
        end
    end

    AST_WAKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level > thr) |=> wake); // R2

    AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_level <= thr) |=> !wake); // R3

endmodule

// File: rtl/lvl7_router.sv
// Module lvl7_router
// Detects the arrival of a valid top-level request and emits a one-cycle
// pulse on the destination chosen by the mode bits. Assumes the mode bits
// are mutually exclusive (guaranteed by the register).
module lvl7_router
    import irq_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic             fast_en,
    input  logic             dma_en,
    output logic             rt_normal,
    output logic             rt_fast,
    output logic             rt_dma
);

    logic   top_now;
    logic   top_seen;
    logic   top_new;
    route_t dest;

    // A top-level request that was not present on the previous cycle.
    always_comb begin
        top_now = req_valid && (req_level == LVL_TOP);
        top_new = top_now && !top_seen;
    end

    // Destination choice, DMA routing taking precedence.
    always_comb begin
        if (dma_en) begin
            dest = RT_DMA;
        end else if (fast_en) begin
            dest = RT_FAST;
        end else begin
            dest = RT_NORMAL;
        end
    end

    // Remember whether a top-level request was present last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_seen <= 1'b0;
        end else begin
            top_seen <= top_now;
        end
    end

    // Registered one-cycle routing pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_normal <= 1'b0;
            rt_fast   <= 1'b0;
            rt_dma    <= 1'b0;
        end else begin
            rt_normal <= top_new && (dest == RT_NORMAL);
            rt_fast   <= top_new && (dest == RT_FAST);
            rt_dma    <= top_new && (dest == RT_DMA);
        end
    end

    AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        top_new |=> ($countones({rt_normal, rt_fast, rt_dma}) == 1)); // R10

    AST_ROUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !top_now |=> !(rt_normal || rt_fast || rt_dma)); // R10

    AST_ROUTE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (top_new && dma_en) |=> rt_dma); // R6

    AST_ROUTE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (top_new && fast_en && !dma_en) |=> rt_fast); // R5

    AST_ROUTE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (top_new && !fast_en && !dma_en) |=> rt_normal); // R11

endmodule

// File: rtl/irq_wake_ctl.sv
// Module irq_wake_ctl
// Top of the interrupt wake threshold controller: configuration register,
// registered wake comparison and level-7 routing. Assumes the request
// inputs come from an upstream arbiter and are synchronous to clk.
module irq_wake_ctl
    import irq_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    output logic             wake,
    output logic             rt_normal,
    output logic             rt_fast,
    output logic             rt_dma
);

    wake_cfg_t cfg;

    wake_cfg_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    wake_cmp u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_level (req_level),
        .thr       (cfg.thr),
        .wake      (wake)
    );

    lvl7_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_level (req_level),
        .fast_en   (cfg.fast_en),
        .dma_en    (cfg.dma_en),
        .rt_normal (rt_normal),
        .rt_fast   (rt_fast),
        .rt_dma    (rt_dma)
    );

    AST_NO_WAKE_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> (!wake && !rt_normal && !rt_fast && !rt_dma)); // R1

endmodule

// File: tb/irq_wake_ctl_test.sv
`timescale 1ns/1ps
module irq_wake_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       req_valid = 1'b0;
    logic [2:0] req_level = 3'd0;
    logic       wake;
    logic       rt_normal;
    logic       rt_fast;
    logic       rt_dma;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic prev_top = 1'b0;

    always #4 clk = ~clk;

    irq_wake_ctl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_level (req_level),
        .wake      (wake),
        .rt_normal (rt_normal),
        .rt_fast   (rt_fast),
        .rt_dma    (rt_dma)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register write with the request held low.
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
        prev_top  = 1'b0;
    endtask

    // One request cycle; mode 0 normal, 1 fast, 2 dma.
    task automatic rq(input logic v, input logic [2:0] lv, input int thr,
                      input int mode, input string req);
        logic top;
        logic pulse;
        @(negedge clk);
        req_valid = v;
        req_level = lv;
        @(posedge clk);
        @(negedge clk);
        top   = v && (lv == 3'd7);
        pulse = top && !prev_top;
        prev_top = top;
        check({req, " wake"}, int'(wake), int'(v && (int'(lv) > thr)));
        check({req, " route"}, int'({rt_normal, rt_fast, rt_dma}),
              pulse ? (mode == 0 ? 4 : (mode == 1 ? 2 : 1)) : 0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prev_top = 1'b0;
    endtask

    task automatic finish_run;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 rdata", int'(cfg_rdata), 0);
        check("R1 outputs", int'({wake, rt_normal, rt_fast, rt_dma}), 0);

        // R2 R3 R4 R10 R11: every threshold against every level and valid.
        for (int t = 0; t < 8; t++) begin
            wr(8'(t));
            check("R4 thr readback", int'(cfg_rdata), t);
            for (int v = 0; v < 2; v++) begin
                for (int l = 0; l < 8; l++) begin
                    rq(v[0], 3'(l), t, 0, "R2 R3 R11 sweep");
                end
            end
        end

        // R10: held level-7 request pulses once.
        wr(8'h00);
        rq(1'b1, 3'd7, 0, 0, "R10 first");
        rq(1'b1, 3'd7, 0, 0, "R10 held");
        rq(1'b1, 3'd6, 0, 0, "R10 lower");
        rq(1'b1, 3'd7, 0, 0, "R10 again");

        // R5 fast routing
        wr(8'h08);
        check("R5 rdata", int'(cfg_rdata), 8'h08);
        rq(1'b1, 3'd7, 0, 1, "R5 fast");
        rq(1'b1, 3'd7, 0, 1, "R5 held");

        // R7 R9: dma set refused while fast on; bits 7,6,4 ignored.
        wr(8'hFF);
        check("R7 R9 rdata", int'(cfg_rdata), 8'h0F);
        wr(8'h20);
        check("R7 rdata", int'(cfg_rdata), 8'h00);
        rq(1'b1, 3'd7, 0, 0, "R7 route normal");

        // R8: setting both at once keeps fast off.
        wr(8'h2B);
        check("R8 both rdata", int'(cfg_rdata), 8'h23);
        rq(1'b1, 3'd7, 3, 2, "R6 dma route");

        // R6 stickiness, R8 fast refused while dma on.
        wr(8'h00);
        check("R6 sticky rdata", int'(cfg_rdata), 8'h20);
        wr(8'h08);
        check("R8 rdata", int'(cfg_rdata), 8'h20);
        rq(1'b1, 3'd7, 0, 2, "R8 route dma");
        rq(1'b0, 3'd7, 0, 2, "R10 invalid");
        wr(8'hD0);
        check("R9 rdata", int'(cfg_rdata), 8'h20);

        // R1 reset clears the sticky bit.
        do_reset();
        check("R1 rdata after reset", int'(cfg_rdata), 0);
        check("R1 outputs after reset", int'({wake, rt_normal, rt_fast, rt_dma}), 0);
        rq(1'b1, 3'd7, 0, 0, "R11 after reset");

        finish_run();
    end

endmodule